// File: doc/BRIEF.md
# Instruction Control-Word Decoder

This block is the control unit for a datapath that runs the base 32-bit integer RISC-V instructions. It reads one instruction word and works out which instruction it is. From that it forms a 6-bit address into a small constant control table. The word stored at that address drives the datapath control pins. The block is purely combinational. The control outputs follow the instruction input within the same cycle, and there is nothing to stall.

Decoding takes three steps. First the 7-bit opcode places the instruction in one of nine groups. Inside a group, funct3 selects among the members, and funct7 is compared only for the members that carry it. Each member has its own match flag. A priority encoder per group turns those flags into that group's table address. The address is then cleared whenever the group is not the active one, and the cleared group addresses are ORed into the final table address. An instruction that nothing recognises lands on address 0. The word at address 0 is a no-op with every enable low.

Top module: `ctrl_decode`

## Requirements
- R1: The opcode in bits 6:0 selects the group. 0110011 is register-register, 0010011 is register-immediate, 0000011 is load, 0100011 is store, 1100011 is branch, 1101111 is jal, 1100111 is jalr, 0110111 is lui and 0010111 is auipc.
- R2: Register-register instructions map to addresses 1 to 10. The order is add, sub, sll, slt, sltu, xor, srl, sra, or, and, for funct3 000,000,001,010,011,100,101,101,110,111. sub and sra need bits 31:25 equal to 0100000. All the others need 0000000.
- R3: Register-immediate instructions map to addresses 11 to 19. The order is addi, slli, slti, sltiu, xori, srli, srai, ori, andi, for funct3 000,001,010,011,100,101,101,110,111. slli and srli need bits 31:25 equal to 0000000, and srai needs 0100000. For the other members the upper bits are free.
- R4: Loads lb, lh, lw, lbu, lhu (funct3 000,001,010,100,101) map to addresses 20 to 24. Stores sb, sh, sw (funct3 000,001,010) map to addresses 25 to 27.
- R5: Branches beq, bne, blt, bge, bltu, bgeu (funct3 000,001,100,101,110,111) map to addresses 28 to 33.
- R6: jal maps to 34, jalr with funct3 000 maps to 35, lui maps to 36 and auipc maps to 37. For jal, lui and auipc, all bits outside the opcode are ignored.
- R7: Any other instruction word gives address 0, and every control output is then 0.
- R8: At most one group produces a non-zero masked address, and the table address is the OR of all masked group addresses.
- R9: alu_sel uses these codes: 0 add, 1 sub, 2 sll, 3 slt, 4 sltu, 5 xor, 6 srl, 7 sra, 8 or, 9 and, 10 pass operand B. Register-register and register-immediate instructions use their own operation. lui uses 10. Every other recognised instruction uses add.
- R10: imm_sel uses these codes: 0 I-form, 1 S-form, 2 B-form, 3 U-form, 4 J-form. Register-immediate, loads and jalr use I. Stores use S, branches use B, lui and auipc use U, and jal uses J. Register-register instructions use 0.
- R11: reg_wen is 1 for register-register, register-immediate, loads, jal, jalr, lui and auipc. mem_wen is 1 only for stores and mem_ren only for loads. reg_wen and mem_wen are never both 1.
- R12: wb_sel is 1 (ALU) for register-register, register-immediate, lui and auipc. It is 2 (pc+4) for jal and jalr, and 0 for everything else. pc_sel is 1 for jal and jalr. br_en is 1 for branches, and br_un is 1 for bltu and bgeu.
- R13: a_sel is 1 (operand A is the pc) for branches, jal and auipc. b_sel is 1 (operand B is the immediate) for every recognised instruction except register-register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inst | input | 32 | Instruction word to decode |
| rom_addr | output | 6 | Control table address |
| imm_sel | output | 3 | Immediate format select |
| alu_sel | output | 4 | ALU operation |
| reg_wen | output | 1 | Register file write enable |
| a_sel | output | 1 | Operand A is pc |
| b_sel | output | 1 | Operand B is immediate |
| mem_wen | output | 1 | Data memory write |
| mem_ren | output | 1 | Data memory read |
| wb_sel | output | 2 | Write-back source |
| pc_sel | output | 1 | Unconditional jump target to pc |
| br_en | output | 1 | Conditional branch |
| br_un | output | 1 | Unsigned branch compare |

## Verification
Every legal instruction is applied with its free fields randomised, so the bench can tell whether a decode depends on bits it should ignore. Random words with an opcode from the table are tried with funct7 drawn as zero, 0100000 or random. This separates the add/sub, srl/sra and srli/srai pairs and catches funct7 words that should be rejected. Fully random words and directed near-misses test the fall-through to the no-op entry: shift-immediates with a wrong funct7, spare funct3 codes in loads, stores, branches and jalr, and opcodes outside the table.

// File: rtl/ctrl_dec_pkg.sv
`timescale 1ns/1ps
package ctrl_dec_pkg;
  localparam int INST_W  = 32;
  localparam int IDX_W   = 6;
  localparam int NGRP    = 9;
  localparam int MAXF    = 10;
  localparam int NUM_ENT = 38;

  localparam int GI_RR = 0, GI_RI = 1, GI_LD = 2, GI_ST = 3, GI_BR = 4;
  localparam int GI_JAL = 5, GI_JALR = 6, GI_LUI = 7, GI_AUIPC = 8;

  localparam logic [6:0] OPC_RR    = 7'b0110011;
  localparam logic [6:0] OPC_RI    = 7'b0010011;
  localparam logic [6:0] OPC_LD    = 7'b0000011;
  localparam logic [6:0] OPC_ST    = 7'b0100011;
  localparam logic [6:0] OPC_BR    = 7'b1100011;
  localparam logic [6:0] OPC_JAL   = 7'b1101111;
  localparam logic [6:0] OPC_JALR  = 7'b1100111;
  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;

  localparam int GRP_NF   [NGRP] = '{10, 9, 5, 3, 6, 1, 1, 1, 1};
  localparam int GRP_BASE [NGRP] = '{1, 11, 20, 25, 28, 34, 35, 36, 37};

  typedef enum logic [2:0] {IMM_I = 3'd0, IMM_S, IMM_B, IMM_U, IMM_J} imm_e;
  typedef enum logic [3:0] {
    ALU_ADD = 4'd0, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU, ALU_XOR,
    ALU_SRL, ALU_SRA, ALU_OR, ALU_AND, ALU_PASSB
  } alu_e;
  typedef enum logic [1:0] {WB_MEM = 2'd0, WB_ALU, WB_PC4} wb_e;

  typedef struct packed {
    imm_e imm_sel;
    alu_e alu_sel;
    logic reg_wen;
    logic a_sel;
    logic b_sel;
    logic mem_wen;
    logic mem_ren;
    wb_e  wb_sel;
    logic pc_sel;
    logic br_en;
    logic br_un;
  } ctrl_t;

  function automatic alu_e rr_op(input int k);
    case (k)
      0: return ALU_ADD;  1: return ALU_SUB;  2: return ALU_SLL;
      3: return ALU_SLT;  4: return ALU_SLTU; 5: return ALU_XOR;
      6: return ALU_SRL;  7: return ALU_SRA;  8: return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction

  function automatic alu_e ri_op(input int k);
    case (k)
      0: return ALU_ADD;  1: return ALU_SLL;  2: return ALU_SLT;
      3: return ALU_SLTU; 4: return ALU_XOR;  5: return ALU_SRL;
      6: return ALU_SRA;  7: return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction

  // Control word held at one table address; unused addresses hold the no-op.
  function automatic ctrl_t rom_entry(input int idx);
    ctrl_t w;
    w = '0;
    if (idx >= 1 && idx <= 10) begin
      w.alu_sel = rr_op(idx - 1);
      w.reg_wen = 1'b1;
      w.wb_sel  = WB_ALU;
    end else if (idx >= 11 && idx <= 19) begin
      w.alu_sel = ri_op(idx - 11);
      w.imm_sel = IMM_I;
      w.b_sel   = 1'b1;
      w.reg_wen = 1'b1;
      w.wb_sel  = WB_ALU;
    end else if (idx >= 20 && idx <= 24) begin
      w.imm_sel = IMM_I;
      w.b_sel   = 1'b1;
      w.reg_wen = 1'b1;
      w.mem_ren = 1'b1;
      w.wb_sel  = WB_MEM;
    end else if (idx >= 25 && idx <= 27) begin
      w.imm_sel = IMM_S;
      w.b_sel   = 1'b1;
      w.mem_wen = 1'b1;
    end else if (idx >= 28 && idx <= 33) begin
      w.imm_sel = IMM_B;
      w.a_sel   = 1'b1;
      w.b_sel   = 1'b1;
      w.br_en   = 1'b1;
      w.br_un   = (idx >= 32);
    end else if (idx == 34) begin
      w.imm_sel = IMM_J;
      w.a_sel   = 1'b1;
      w.b_sel   = 1'b1;
      w.reg_wen = 1'b1;
      w.wb_sel  = WB_PC4;
      w.pc_sel  = 1'b1;
    end else if (idx == 35) begin
      w.imm_sel = IMM_I;
      w.b_sel   = 1'b1;
      w.reg_wen = 1'b1;
      w.wb_sel  = WB_PC4;
      w.pc_sel  = 1'b1;
    end else if (idx == 36) begin
      w.imm_sel = IMM_U;
      w.alu_sel = ALU_PASSB;
      w.b_sel   = 1'b1;
      w.reg_wen = 1'b1;
      w.wb_sel  = WB_ALU;
    end else if (idx == 37) begin
      w.imm_sel = IMM_U;
      w.a_sel   = 1'b1;
      w.b_sel   = 1'b1;
      w.reg_wen = 1'b1;
      w.wb_sel  = WB_ALU;
    end
    return w;
  endfunction
endpackage

// File: rtl/insn_classify.sv
`timescale 1ns/1ps
module insn_classify
  import ctrl_dec_pkg::*;
(
  input  logic [INST_W-1:0]           inst,
  output logic [NGRP-1:0]             grp_act,
  output logic [NGRP-1:0][MAXF-1:0]   hits
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic       f7_zero;
  logic       f7_alt;
  logic       unused_fields;

  assign opc     = inst[6:0];
  assign f3      = inst[14:12];
  assign f7      = inst[31:25];
  assign f7_zero = (f7 == 7'b0000000);
  assign f7_alt  = (f7 == 7'b0100000);
  assign unused_fields = ^{inst[24:15], inst[11:7]};

  // Level 1: opcode to group
  always_comb begin
    grp_act = '0;
    case (opc)
      OPC_RR:    grp_act[GI_RR]    = 1'b1;
      OPC_RI:    grp_act[GI_RI]    = 1'b1;
      OPC_LD:    grp_act[GI_LD]    = 1'b1;
      OPC_ST:    grp_act[GI_ST]    = 1'b1;
      OPC_BR:    grp_act[GI_BR]    = 1'b1;
      OPC_JAL:   grp_act[GI_JAL]   = 1'b1;
      OPC_JALR:  grp_act[GI_JALR]  = 1'b1;
      OPC_LUI:   grp_act[GI_LUI]   = 1'b1;
      OPC_AUIPC: grp_act[GI_AUIPC] = 1'b1;
      default:   grp_act = '0;
    endcase
  end

  // Levels 2 and 3: funct3, then funct7 where the member carries one
  always_comb begin
    hits = '0;
    hits[GI_RR][0] = grp_act[GI_RR] && f3 == 3'b000 && f7_zero;
    hits[GI_RR][1] = grp_act[GI_RR] && f3 == 3'b000 && f7_alt;
    hits[GI_RR][2] = grp_act[GI_RR] && f3 == 3'b001 && f7_zero;
    hits[GI_RR][3] = grp_act[GI_RR] && f3 == 3'b010 && f7_zero;
    hits[GI_RR][4] = grp_act[GI_RR] && f3 == 3'b011 && f7_zero;
    hits[GI_RR][5] = grp_act[GI_RR] && f3 == 3'b100 && f7_zero;
    hits[GI_RR][6] = grp_act[GI_RR] && f3 == 3'b101 && f7_zero;
    hits[GI_RR][7] = grp_act[GI_RR] && f3 == 3'b101 && f7_alt;
    hits[GI_RR][8] = grp_act[GI_RR] && f3 == 3'b110 && f7_zero;
    hits[GI_RR][9] = grp_act[GI_RR] && f3 == 3'b111 && f7_zero;

    hits[GI_RI][0] = grp_act[GI_RI] && f3 == 3'b000;
    hits[GI_RI][1] = grp_act[GI_RI] && f3 == 3'b001 && f7_zero;
    hits[GI_RI][2] = grp_act[GI_RI] && f3 == 3'b010;
    hits[GI_RI][3] = grp_act[GI_RI] && f3 == 3'b011;
    hits[GI_RI][4] = grp_act[GI_RI] && f3 == 3'b100;
    hits[GI_RI][5] = grp_act[GI_RI] && f3 == 3'b101 && f7_zero;
    hits[GI_RI][6] = grp_act[GI_RI] && f3 == 3'b101 && f7_alt;
    hits[GI_RI][7] = grp_act[GI_RI] && f3 == 3'b110;
    hits[GI_RI][8] = grp_act[GI_RI] && f3 == 3'b111;

    hits[GI_LD][0] = grp_act[GI_LD] && f3 == 3'b000;
    hits[GI_LD][1] = grp_act[GI_LD] && f3 == 3'b001;
    hits[GI_LD][2] = grp_act[GI_LD] && f3 == 3'b010;
    hits[GI_LD][3] = grp_act[GI_LD] && f3 == 3'b100;
    hits[GI_LD][4] = grp_act[GI_LD] && f3 == 3'b101;

    hits[GI_ST][0] = grp_act[GI_ST] && f3 == 3'b000;
    hits[GI_ST][1] = grp_act[GI_ST] && f3 == 3'b001;
    hits[GI_ST][2] = grp_act[GI_ST] && f3 == 3'b010;

    hits[GI_BR][0] = grp_act[GI_BR] && f3 == 3'b000;
    hits[GI_BR][1] = grp_act[GI_BR] && f3 == 3'b001;
    hits[GI_BR][2] = grp_act[GI_BR] && f3 == 3'b100;
    hits[GI_BR][3] = grp_act[GI_BR] && f3 == 3'b101;
    hits[GI_BR][4] = grp_act[GI_BR] && f3 == 3'b110;
    hits[GI_BR][5] = grp_act[GI_BR] && f3 == 3'b111;

    hits[GI_JAL][0]   = grp_act[GI_JAL];
    hits[GI_JALR][0]  = grp_act[GI_JALR] && f3 == 3'b000;
    hits[GI_LUI][0]   = grp_act[GI_LUI];
    hits[GI_AUIPC][0] = grp_act[GI_AUIPC];
  end
endmodule

// File: rtl/grp_pe.sv
`timescale 1ns/1ps
module grp_pe
  import ctrl_dec_pkg::*;
#(
  parameter int NF   = 1,
  parameter int BASE = 1
) (
  input  logic              active,
  input  logic [MAXF-1:0]   hits,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0] enc;

  // Lowest-numbered member wins
  always_comb begin
    enc = '0;
    for (int k = NF - 1; k >= 0; k--) begin
      if (hits[k]) enc = IDX_W'(BASE + k);
    end
  end

  // Clear the group address unless this group owns the opcode
  assign idx = enc & {IDX_W{active}};

  always_comb begin
    assert_spare_hits_clear_R8: assert ((hits >> NF) == '0)
      else $error("member flag beyond group size");
    if (active) begin
      assert_one_member_R8: assert ($onehot0(hits))
        else $error("several members match at once");
    end else begin
      assert_idle_group_quiet_R8: assert (hits == '0)
        else $error("member flag raised in an inactive group");
    end
  end
endmodule

// File: rtl/ctrl_rom.sv
`timescale 1ns/1ps
module ctrl_rom
  import ctrl_dec_pkg::*;
#(
  parameter int DEPTH = 1 << IDX_W
) (
  input  logic [IDX_W-1:0] addr,
  output ctrl_t            word
);
  ctrl_t rom_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign rom_q[i] = rom_entry(i);
  end

  assign word = rom_q[addr];
endmodule

// File: rtl/ctrl_decode.sv
`timescale 1ns/1ps
module ctrl_decode
  import ctrl_dec_pkg::*;
(
  input  logic [31:0] inst,
  output logic [5:0]  rom_addr,
  output logic [2:0]  imm_sel,
  output logic [3:0]  alu_sel,
  output logic        reg_wen,
  output logic        a_sel,
  output logic        b_sel,
  output logic        mem_wen,
  output logic        mem_ren,
  output logic [1:0]  wb_sel,
  output logic        pc_sel,
  output logic        br_en,
  output logic        br_un
);
  logic [NGRP-1:0]              grp_act;
  logic [NGRP-1:0][MAXF-1:0]    hits;
  logic [NGRP-1:0][IDX_W-1:0]   grp_idx;
  logic [NGRP-1:0]              grp_nz;
  ctrl_t                        cw;

  insn_classify u_cls (
    .inst    (inst),
    .grp_act (grp_act),
    .hits    (hits)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    grp_pe #(
      .NF   (GRP_NF[g]),
      .BASE (GRP_BASE[g])
    ) u_pe (
      .active (grp_act[g]),
      .hits   (hits[g]),
      .idx    (grp_idx[g])
    );
  end

  // Merge: every inactive group contributes zero
  always_comb begin
    rom_addr = '0;
    grp_nz   = '0;
    for (int g = 0; g < NGRP; g++) begin
      rom_addr  = rom_addr | grp_idx[g];
      grp_nz[g] = |grp_idx[g];
    end
  end

  ctrl_rom u_rom (
    .addr (rom_addr),
    .word (cw)
  );

  assign imm_sel = cw.imm_sel;
  assign alu_sel = cw.alu_sel;
  assign reg_wen = cw.reg_wen;
  assign a_sel   = cw.a_sel;
  assign b_sel   = cw.b_sel;
  assign mem_wen = cw.mem_wen;
  assign mem_ren = cw.mem_ren;
  assign wb_sel  = cw.wb_sel;
  assign pc_sel  = cw.pc_sel;
  assign br_en   = cw.br_en;
  assign br_un   = cw.br_un;

  always_comb begin
    assert_single_group_R8: assert ($countones(grp_nz) <= 1)
      else $error("more than one group drives the table address");
    assert_addr_in_table_R7: assert (int'(rom_addr) < NUM_ENT)
      else $error("table address beyond populated entries");
    if (grp_act == '0) begin
      assert_unknown_is_nop_R7: assert (cw == '0)
        else $error("unknown opcode did not yield the no-op word");
    end
    assert_no_reg_and_mem_write_R11: assert (!(cw.reg_wen && cw.mem_wen))
      else $error("register and memory write both enabled");
  end
endmodule

// File: tb/ctrl_decode_tb.sv
`timescale 1ns/1ps
module ctrl_decode_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [31:0] inst;
  logic [5:0]  rom_addr;
  logic [2:0]  imm_sel;
  logic [3:0]  alu_sel;
  logic        reg_wen, a_sel, b_sel, mem_wen, mem_ren;
  logic [1:0]  wb_sel;
  logic        pc_sel, br_en, br_un;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit seen [38];

  ctrl_decode u_dut (
    .inst (inst), .rom_addr (rom_addr), .imm_sel (imm_sel), .alu_sel (alu_sel),
    .reg_wen (reg_wen), .a_sel (a_sel), .b_sel (b_sel), .mem_wen (mem_wen),
    .mem_ren (mem_ren), .wb_sel (wb_sel), .pc_sel (pc_sel), .br_en (br_en),
    .br_un (br_un)
  );

  // Expected table address, written as one flat pattern list (R1..R7)
  function automatic int exp_idx(input logic [31:0] i);
    casez ({i[31:25], i[14:12], i[6:0]})
      17'b0000000_000_0110011: return 1;
      17'b0100000_000_0110011: return 2;
      17'b0000000_001_0110011: return 3;
      17'b0000000_010_0110011: return 4;
      17'b0000000_011_0110011: return 5;
      17'b0000000_100_0110011: return 6;
      17'b0000000_101_0110011: return 7;
      17'b0100000_101_0110011: return 8;
      17'b0000000_110_0110011: return 9;
      17'b0000000_111_0110011: return 10;
      17'b???????_000_0010011: return 11;
      17'b0000000_001_0010011: return 12;
      17'b???????_010_0010011: return 13;
      17'b???????_011_0010011: return 14;
      17'b???????_100_0010011: return 15;
      17'b0000000_101_0010011: return 16;
      17'b0100000_101_0010011: return 17;
      17'b???????_110_0010011: return 18;
      17'b???????_111_0010011: return 19;
      17'b???????_000_0000011: return 20;
      17'b???????_001_0000011: return 21;
      17'b???????_010_0000011: return 22;
      17'b???????_100_0000011: return 23;
      17'b???????_101_0000011: return 24;
      17'b???????_000_0100011: return 25;
      17'b???????_001_0100011: return 26;
      17'b???????_010_0100011: return 27;
      17'b???????_000_1100011: return 28;
      17'b???????_001_1100011: return 29;
      17'b???????_100_1100011: return 30;
      17'b???????_101_1100011: return 31;
      17'b???????_110_1100011: return 32;
      17'b???????_111_1100011: return 33;
      17'b???????_???_1101111: return 34;
      17'b???????_000_1100111: return 35;
      17'b???????_???_0110111: return 36;
      17'b???????_???_0010111: return 37;
      default:                 return 0;
    endcase
  endfunction

  function automatic string grp_tag(input int e);
    if (e == 0)  return "R7";
    if (e <= 10) return "R2";
    if (e <= 19) return "R3";
    if (e <= 27) return "R4";
    if (e <= 33) return "R5";
    return "R6";
  endfunction

  // R9: alu codes
  function automatic logic [3:0] exp_alu(input int e);
    case (e)
      1, 11:  return 4'd0;
      2:      return 4'd1;
      3, 12:  return 4'd2;
      4, 13:  return 4'd3;
      5, 14:  return 4'd4;
      6, 15:  return 4'd5;
      7, 16:  return 4'd6;
      8, 17:  return 4'd7;
      9, 18:  return 4'd8;
      10, 19: return 4'd9;
      36:     return 4'd10;
      default: return 4'd0;
    endcase
  endfunction

  // R10: immediate formats
  function automatic logic [2:0] exp_imm(input int e);
    if (e >= 25 && e <= 27) return 3'd1;
    if (e >= 28 && e <= 33) return 3'd2;
    if (e == 36 || e == 37) return 3'd3;
    if (e == 34)            return 3'd4;
    return 3'd0;
  endfunction

  // R11: {reg_wen, mem_wen, mem_ren}
  function automatic logic [2:0] exp_en(input int e);
    logic rw;
    rw = (e >= 1 && e <= 24) || (e >= 34 && e <= 37);
    return {rw, (e >= 25 && e <= 27), (e >= 20 && e <= 24)};
  endfunction

  // R12: {wb_sel, pc_sel, br_en, br_un}
  function automatic logic [4:0] exp_flow(input int e);
    logic [1:0] wb;
    wb = 2'd0;
    if ((e >= 1 && e <= 19) || e == 36 || e == 37) wb = 2'd1;
    if (e == 34 || e == 35) wb = 2'd2;
    return {wb, (e == 34 || e == 35), (e >= 28 && e <= 33), (e == 32 || e == 33)};
  endfunction

  // R13: {a_sel, b_sel}
  function automatic logic [1:0] exp_opnd(input int e);
    return {((e >= 28 && e <= 34) || e == 37), (e >= 11)};
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] i,
                     input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s inst=%08h actual=%0d expected=%0d", tag, what, i, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] i);
    int e;
    @(posedge clk);
    inst <= i;
    @(negedge clk);
    e = exp_idx(i);
    seen[e] = 1'b1;
    cmp(grp_tag(e), "rom_addr", i, int'(rom_addr), e);
    cmp("R9",  "alu_sel", i, int'(alu_sel), int'(exp_alu(e)));
    cmp("R10", "imm_sel", i, int'(imm_sel), int'(exp_imm(e)));
    cmp("R11", "enables", i, int'({reg_wen, mem_wen, mem_ren}), int'(exp_en(e)));
    cmp("R12", "flow",    i, int'({wb_sel, pc_sel, br_en, br_un}), int'(exp_flow(e)));
    cmp("R13", "operand", i, int'({a_sel, b_sel}), int'(exp_opnd(e)));
  endtask

  function automatic logic [6:0] pick_opc(input int k);
    case (k)
      0: return 7'b0110011; 1: return 7'b0010011; 2: return 7'b0000011;
      3: return 7'b0100011; 4: return 7'b1100011; 5: return 7'b1101111;
      6: return 7'b1100111; 7: return 7'b0110111;
      default: return 7'b0010111;
    endcase
  endfunction

  function automatic logic [31:0] rnd_legal_opc();
    logic [31:0] r;
    logic [6:0]  f7;
    r = $urandom;
    case ($urandom_range(0, 2))
      0: f7 = 7'b0000000;
      1: f7 = 7'b0100000;
      default: f7 = r[31:25];
    endcase
    return {f7, r[24:7], pick_opc($urandom_range(0, 8))};
  endfunction

  function automatic void show_summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      show_summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    inst  = 32'h0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    // Reset-phase: all-zero word is unrecognised, so the no-op word appears (R7)
    @(negedge clk);
    cmp("R7", "reset rom_addr", inst, int'(rom_addr), 0);
    cmp("R7", "reset controls", inst,
        int'({imm_sel, alu_sel, reg_wen, a_sel, b_sel, mem_wen, mem_ren,
              wb_sel, pc_sel, br_en, br_un}), 0);
    rst_n = 1'b1;

    // R1: each opcode with funct3/funct7 zero lands inside its group
    for (int k = 0; k < 9; k++) begin
      int e;
      @(posedge clk);
      inst <= {25'h0, pick_opc(k)};
      @(negedge clk);
      e = exp_idx({25'h0, pick_opc(k)});
      cmp("R1", "group of opcode", {25'h0, pick_opc(k)}, int'(rom_addr), e);
    end

    // Directed corners: near-misses and ignored fields (R2..R7)
    drive(32'h0000_0000);
    drive(32'hFFFF_FFFF);
    drive({7'b0000001, 10'h155, 3'b000, 5'd3, 7'b0110011}); // funct7 01: rejected R2
    drive({7'b0100000, 10'h0AA, 3'b001, 5'd3, 7'b0110011}); // sll with alt funct7 R2
    drive({7'b0100000, 10'h0AA, 3'b000, 5'd3, 7'b0110011}); // sub R2
    drive({7'b0100000, 10'h0AA, 3'b001, 5'd4, 7'b0010011}); // slli bad funct7 R3
    drive({7'b0000001, 10'h0AA, 3'b101, 5'd4, 7'b0010011}); // srli bad funct7 R3
    drive({7'b0100000, 10'h0AA, 3'b101, 5'd4, 7'b0010011}); // srai R3
    drive({12'hFFF, 5'd1, 3'b000, 5'd1, 7'b0010011});       // addi, all-ones imm R3
    drive({7'h7F, 10'h3FF, 3'b011, 5'd9, 7'b0000011});      // load spare funct3 R4
    drive({7'h7F, 10'h3FF, 3'b110, 5'd9, 7'b0000011});
    drive({7'h11, 10'h123, 3'b100, 5'd9, 7'b0100011});      // store spare funct3 R4
    drive({7'h11, 10'h123, 3'b010, 5'd9, 7'b1100011});      // branch spare R5
    drive({7'h11, 10'h123, 3'b011, 5'd9, 7'b1100011});
    drive({7'h11, 10'h123, 3'b110, 5'd9, 7'b1100011});      // bltu R5
    drive({7'h11, 10'h123, 3'b010, 5'd9, 7'b1100111});      // jalr bad funct3 R6
    drive({7'h7F, 10'h3FF, 3'b111, 5'd31, 7'b1101111});     // jal, fields ignored R6
    drive({7'h7F, 10'h3FF, 3'b101, 5'd31, 7'b0110111});     // lui R6
    drive({7'h55, 10'h2AA, 3'b010, 5'd7, 7'b0010111});      // auipc R6
    drive({25'h0, 7'b0001111});                              // opcode outside table R7
    drive({25'h0, 7'b1110011});
    drive({25'h0, 7'b0110001});                              // low bits not 11 R7

    // Random words with a legal opcode (R2..R13)
    for (int n = 0; n < 5000; n++) drive(rnd_legal_opc());
    // Fully random words, mostly the fall-through case (R7, R8)
    for (int n = 0; n < 1500; n++) drive($urandom);

    // Every table entry reached at least once (R8 merge covers each group)
    for (int k = 0; k < 38; k++) cmp("R8", "entry reached", 32'(k), int'(seen[k]), 1);

    done = 1'b1;
    show_summary();
    $finish;
  end
endmodule